// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a down-counting interval timer for a processor subsystem. It sits behind a narrow word-wide register port. Software loads a period, arms the counter, and can then either poll a sticky wrap flag or take a one-cycle interrupt pulse each time the count passes through zero. The count advances either on every core clock or on rising edges of an external slow reference strobe. The strobe is first brought into the core clock domain.

Each request is answered with a registered response one cycle later. Requests from non-privileged masters and requests that are not a full word get an error response, and nothing inside the block changes. A fixed calibration word is readable, and offsets that match no register read as zero.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset the control word, the period register and the live count are all zero, and no interrupt is pending.
- R2: The registers sit at byte offsets 0x0 (control), 0x4 (period), 0x8 (live count) and 0xC (calibration). Any other offset reads zero without an error, and a write to it changes nothing. The period and count are CNT_W bits wide, and the bits above them read as zero.
- R3: The control word has arm at bit 0, interrupt enable at bit 1, source select at bit 2 and the wrap flag at bit 16. A write changes bits 2:0 only.
- R4: A period is P+1 ticks, where P is the period register. Arming the counter (bit 0 going from 0 to 1) loads P. With a tick on every cycle, the first wrap interrupt comes P+1 cycles after the arming write, and each later one comes P+1 cycles after the one before.
- R5: Every wrap sets the flag, whether or not interrupts are enabled. A privileged read of the control word returns the flag and then clears it. A wrap in the same cycle as that read keeps the flag set.
- R6: The interrupt output is a pulse one cycle long, and it is raised for a wrap only while bit 1 is set.
- R7: If P is zero when a wrap occurs, the arm bit clears and counting stops after that single wrap.
- R8: Writing any value to the live-count offset reloads the count from P and clears the flag. The next wrap then comes P+1 ticks later.
- R9: Reading the live count returns zero while the counter is disarmed, and also returns zero when the count is larger than P. Right after arming it reads P.
- R10: The calibration offset always reads 10000 decimal.
- R11: A request with the privilege input low, or with a size code other than 2 (word; 0 is byte, 1 is half), gets an error response with zero read data. It has no side effect: it does not write a register and it does not clear the flag.
- R12: With source select 1 the count advances every core cycle. With select 0 it advances once per rising edge of the reference strobe, after a two-stage synchroniser, so a strobe held high counts once. Changing the select while armed reloads the count from P.
- R13: Each request is answered by a response valid exactly one cycle later, and there is no response without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_size | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| req_priv | input | 1 | High when the master is privileged |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_err | output | 1 | Error response, with no effect on state |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| ref_tick | input | 1 | Asynchronous external reference strobe |
| irq | output | 1 | One-cycle wrap interrupt pulse |

## Verification
The bench builds the timer with CNT_W = 8, so writing all ones to the period register shows the truncation to eight bits. It sweeps the period exhaustively from 1 to 20 and times each sweep point in core cycles, checking both the latency from arming to the first interrupt and the spacing between interrupts. A period of zero covers the one-shot stop. Short periods keep the reference-strobe tests within tens of cycles, so those tests can count wraps exactly per strobe edge. They also show that a strobe held high for many cycles advances the count only once.

// File: rtl/ptt_pkg.sv
// Package: shared constants and types for the periodic tick timer.
// Assumes a 32-bit register data path and byte offsets on the request port.
package ptt_pkg;

    localparam int DATA_W = 32;

    // Byte offsets of the four registers
    localparam int OFS_CTRL    = 'h0;
    localparam int OFS_PERIOD  = 'h4;
    localparam int OFS_COUNT   = 'h8;
    localparam int OFS_CALIB   = 'hC;

    // Control word bit positions
    localparam int BIT_ARM     = 0;
    localparam int BIT_IRQ_EN  = 1;
    localparam int BIT_SRC     = 2;
    localparam int BIT_WRAP    = 16;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic ctrl;
        logic period;
        logic count;
        logic calib;
    } reg_sel_t;

endpackage

// File: rtl/ptt_ref_sync.sv
// Module: brings the asynchronous reference strobe into the core clock domain
// and emits a one-cycle pulse for each rising edge.
// Assumes STAGES >= 2 and a strobe that stays low or high for at least two core cycles.
module ptt_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic edge_pulse
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the strobe through the synchroniser chain and keep the last stable level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], strobe_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Rising edge of the synchronised level
    always_comb begin
        edge_pulse = sync_q[STAGES-1] & ~prev_q;
    end

endmodule

// File: rtl/ptt_access_decode.sv
// Module: checks a register request and decodes its offset.
// An error is a request that is unprivileged or not a full word. The select
// and read/write strobes are forced low for errored requests, so such a
// request cannot touch any state. Unmatched offsets leave every select low.
module ptt_access_decode
    import ptt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_priv,
    output logic              acc_err,
    output logic              acc_rd,
    output logic              acc_wr,
    output reg_sel_t          sel
);

    logic acc_ok;

    // Legality check: privileged full-word requests only
    always_comb begin
        acc_ok  = req_valid & req_priv & (acc_size_e'(req_size) == ACC_WORD);
        acc_err = req_valid & ~acc_ok;
        acc_rd  = acc_ok & ~req_write;
        acc_wr  = acc_ok &  req_write;
    end

    // Offset decode, gated by legality
    always_comb begin
        sel        = '0;
        sel.ctrl   = acc_ok & (req_addr == ADDR_W'(OFS_CTRL));
        sel.period = acc_ok & (req_addr == ADDR_W'(OFS_PERIOD));
        sel.count  = acc_ok & (req_addr == ADDR_W'(OFS_COUNT));
        sel.calib  = acc_ok & (req_addr == ADDR_W'(OFS_CALIB));
    end

endmodule

// File: rtl/ptt_down_counter.sv
// Module: the period down-counter.
// A load puts load_val into the counter and takes priority over counting.
// While running, each tick decrements the count. A tick at zero is a wrap:
// the count reloads from load_val and expire is high for that cycle.
// A wrap cannot coincide with a load.
module ptt_down_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    // Wrap detect: a running tick while the count is zero and no load is pending
    always_comb begin
        expire = run & tick & ~load & (count == '0);
    end

    // Count register: load, wrap-reload or decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (run && tick) begin
            if (count == '0) begin
                count <= load_val;
            end else begin
                count <= count - 1'b1;
            end
        end
    end

endmodule

// File: rtl/periodic_tick_timer.sv
// Module: top of the periodic tick timer. It holds the control bits, the
// period register and the wrap flag, picks the tick source, builds the read
// data and registers the response and the interrupt pulse.
// Assumes 8 <= CNT_W < 32 and one request per cycle; the response follows one cycle later.
module periodic_tick_timer
    import ptt_pkg::*;
#(
    parameter int          CNT_W       = 24,
    parameter int          ADDR_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] CAL_VALUE   = 32'd10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_priv,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    input  logic              ref_tick,
    output logic              irq
);

    localparam int PAD_W = DATA_W - CNT_W;

    logic             acc_err, acc_rd, acc_wr;
    reg_sel_t         sel;
    logic             arm_q, irq_en_q, src_q, wrap_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] count_vis;
    logic             ref_pulse, tick, load, expire;
    logic             wr_ctrl, wr_period, wr_count, rd_ctrl;
    logic             arm_rise, src_change;
    logic [31:0]      ctrl_word, rd_data;
    logic             unused_wdata_hi;

    ptt_access_decode #(
        .ADDR_W(ADDR_W)
    ) u_decode (
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_size (req_size),
        .req_priv (req_priv),
        .acc_err  (acc_err),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .sel      (sel)
    );

    ptt_ref_sync #(
        .STAGES(SYNC_STAGES)
    ) u_ref_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_in (ref_tick),
        .edge_pulse(ref_pulse)
    );

    ptt_down_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(period_q),
        .run     (arm_q),
        .tick    (tick),
        .count   (count),
        .expire  (expire)
    );

    // Per-register strobes and the events that restart the period
    always_comb begin
        wr_ctrl    = acc_wr & sel.ctrl;
        wr_period  = acc_wr & sel.period;
        wr_count   = acc_wr & sel.count;
        rd_ctrl    = acc_rd & sel.ctrl;
        arm_rise   = wr_ctrl & req_wdata[BIT_ARM] & ~arm_q;
        src_change = wr_ctrl & req_wdata[BIT_ARM] & arm_q & (req_wdata[BIT_SRC] != src_q);
        load       = wr_count | arm_rise | src_change;
        tick       = src_q ? 1'b1 : ref_pulse;
    end

    // Write-data bits above the counter width are not stored anywhere
    assign unused_wdata_hi = ^req_wdata[DATA_W-1:CNT_W];

    // Control bits: a software write wins, otherwise a wrap with a zero period disarms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q    <= 1'b0;
            irq_en_q <= 1'b0;
            src_q    <= 1'b0;
        end else if (wr_ctrl) begin
            arm_q    <= req_wdata[BIT_ARM];
            irq_en_q <= req_wdata[BIT_IRQ_EN];
            src_q    <= req_wdata[BIT_SRC];
        end else if (expire && period_q == '0) begin
            arm_q    <= 1'b0;
        end
    end

    // Wrap flag: set by a wrap, which outranks the clear by a control read or count write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_q <= 1'b0;
        end else if (expire) begin
            wrap_q <= 1'b1;
        end else if (rd_ctrl || wr_count) begin
            wrap_q <= 1'b0;
        end
    end

    // Period register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
        end else if (wr_period) begin
            period_q <= req_wdata[CNT_W-1:0];
        end
    end

    // Visible count: zero while disarmed or above the period
    always_comb begin
        count_vis = (arm_q && count <= period_q) ? count : '0;
    end

    // Control word assembly
    always_comb begin
        ctrl_word             = '0;
        ctrl_word[BIT_ARM]    = arm_q;
        ctrl_word[BIT_IRQ_EN] = irq_en_q;
        ctrl_word[BIT_SRC]    = src_q;
        ctrl_word[BIT_WRAP]   = wrap_q;
    end

    // Read data multiplexer
    always_comb begin
        rd_data = '0;
        if (acc_rd) begin
            if (sel.ctrl) begin
                rd_data = ctrl_word;
            end else if (sel.period) begin
                rd_data = {{PAD_W{1'b0}}, period_q};
            end else if (sel.count) begin
                rd_data = {{PAD_W{1'b0}}, count_vis};
            end else if (sel.calib) begin
                rd_data = CAL_VALUE;
            end
        end
    end

    // Registered response, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= acc_err;
            rsp_rdata <= rd_data;
        end
    end

    // Interrupt pulse for a wrap while interrupts are enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= expire & irq_en_q;
        end
    end

endmodule

// File: rtl/ptt_checker.sv
// Module: timing properties of the periodic tick timer, bound to the top module.
module ptt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_priv,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata,
    input logic        irq,
    input logic        irq_en,
    input logic        wrap_flag,
    input logic        arm
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!arm && !wrap_flag && !irq && !rsp_valid));

    assert_rsp_follows_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_stray_rsp_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_unpriv_errors_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_priv) |=> rsp_err);

    assert_err_zero_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'd0));

    assert_irq_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));

    assert_flag_with_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wrap_flag);

endmodule

bind periodic_tick_timer ptt_checker u_ptt_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_priv (req_priv),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .irq      (irq),
    .irq_en   (irq_en_q),
    .wrap_flag(wrap_q),
    .arm      (arm_q)
);

// File: tb/test_periodic_tick_timer.sv
module test_periodic_tick_timer;

    localparam int CNT_W  = 8;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = 2'd2;
    logic              req_priv = 1'b1;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [31:0]       rsp_rdata;
    logic              ref_tick = 1'b0;
    logic              irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int irq_cnt = 0;
    int irq_stamp [0:511];
    bit finished = 0;

    logic [31:0] last_rd;
    logic        last_err, last_vld;

    periodic_tick_timer #(
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W)
    ) i_periodic_tick_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_size (req_size),
        .req_priv (req_priv),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_err  (rsp_err),
        .rsp_rdata(rsp_rdata),
        .ref_tick (ref_tick),
        .irq      (irq)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (irq) begin
            irq_stamp[irq_cnt] = cyc;
            irq_cnt = irq_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%08h), expected %0d (0x%08h)", req, act, act, exp, exp);
        end
    endtask

    task automatic bus(input bit wr, input logic [7:0] a, input logic [31:0] d,
                       input bit pv, input logic [1:0] sz);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        req_priv = pv; req_size = sz;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_priv = 1'b1; req_size = 2'd2;
        last_rd = rsp_rdata; last_err = rsp_err; last_vld = rsp_valid;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        bus(1'b1, a, d, 1'b1, 2'd2);
    endtask

    task automatic rd_reg(input logic [7:0] a);
        bus(1'b0, a, 32'd0, 1'b1, 2'd2);
    endtask

    task automatic wait_irq(input int target);
        for (int i = 0; i < 400 && irq_cnt < target; i++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ref(input int hi, input int lo);
        ref_tick = 1'b1; idle(hi);
        ref_tick = 1'b0; idle(lo);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base, t0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state, R13 response timing
        rd_reg(8'h0); chk("R1 ctrl", last_rd, 0);
        chk("R13 rsp_valid", last_vld, 1);
        rd_reg(8'h4); chk("R1 period", last_rd, 0);
        rd_reg(8'h8); chk("R1 count", last_rd, 0);
        chk("R1 irq", irq, 0);

        // R10 calibration
        rd_reg(8'hC); chk("R10 calib", last_rd, 10000);

        // R2 unmapped offset and width truncation
        wr_reg(8'h10, 32'hFFFF_FFFF);
        rd_reg(8'h10); chk("R2 unmapped read", last_rd, 0);
        chk("R2 unmapped no err", last_err, 0);
        rd_reg(8'h0);  chk("R2 ctrl untouched", last_rd, 0);
        rd_reg(8'h4);  chk("R2 period untouched", last_rd, 0);
        wr_reg(8'h4, 32'hFFFF_FFFF);
        rd_reg(8'h4);  chk("R2 period width", last_rd, 32'hFF);

        // R3 only bits 2:0 writable
        wr_reg(8'h0, 32'hFFFF_FFF8);
        rd_reg(8'h0);  chk("R3 upper bits ignored", last_rd, 0);

        // R11 illegal accesses
        bus(1'b1, 8'h4, 32'h33, 1'b0, 2'd2); chk("R11 unpriv write err", last_err, 1);
        rd_reg(8'h4); chk("R11 unpriv write no effect", last_rd, 32'hFF);
        bus(1'b0, 8'hC, 32'h0, 1'b1, 2'd0); chk("R11 byte read err", last_err, 1);
        chk("R11 byte read data", last_rd, 0);
        bus(1'b1, 8'h4, 32'h12, 1'b1, 2'd1); chk("R11 half write err", last_err, 1);
        rd_reg(8'h4); chk("R11 half write no effect", last_rd, 32'hFF);

        // R4 period sweep with core-clock ticks
        for (int r = 1; r <= 20; r++) begin
            wr_reg(8'h4, r);
            wr_reg(8'h0, 32'h0);
            wr_reg(8'h0, 32'h7);
            t0 = cyc; base = irq_cnt;
            wait_irq(base + 2);
            chk($sformatf("R4 first wrap latency P=%0d", r), irq_stamp[base] - t0, r + 1);
            chk($sformatf("R4 wrap spacing P=%0d", r), irq_stamp[base + 1] - irq_stamp[base], r + 1);
        end
        wr_reg(8'h0, 32'h0);
        rd_reg(8'h0);

        // R9 visible count
        rd_reg(8'h8); chk("R9 disarmed count", last_rd, 0);
        wr_reg(8'h4, 50);
        wr_reg(8'h0, 32'h7);
        rd_reg(8'h8); chk("R9 count after arm", last_rd, 50);
        idle(3);
        wr_reg(8'h4, 5);
        rd_reg(8'h8); chk("R9 count above period", last_rd, 0);
        wr_reg(8'h0, 32'h0);
        rd_reg(8'h0);

        // R7 zero period one-shot
        wr_reg(8'h4, 0);
        base = irq_cnt;
        wr_reg(8'h0, 32'h7);
        idle(10);
        chk("R7 single wrap", irq_cnt - base, 1);
        rd_reg(8'h0); chk("R7 disarmed with flag", last_rd, 32'h0001_0006);
        rd_reg(8'h0); chk("R5 flag cleared by read", last_rd, 32'h6);

        // R6 no interrupt while disabled, R5 flag still set
        wr_reg(8'h4, 3);
        base = irq_cnt;
        wr_reg(8'h0, 32'h5);
        idle(20);
        chk("R6 no irq when disabled", irq_cnt - base, 0);
        rd_reg(8'h0); chk("R5 flag without irq", last_rd, 32'h0001_0005);

        // R8 count write clears flag and restarts
        idle(10);
        wr_reg(8'h8, 32'h1234);
        rd_reg(8'h0); chk("R8 flag cleared by count write", last_rd, 32'h5);
        wr_reg(8'h0, 32'h7);
        idle(2);
        wr_reg(8'h8, 32'hABCD);
        t0 = cyc; base = irq_cnt;
        wait_irq(base + 1);
        chk("R8 restart latency", irq_stamp[base] - t0, 4);

        // R11 unprivileged read leaves flag set
        idle(10);
        bus(1'b0, 8'h0, 32'h0, 1'b0, 2'd2);
        chk("R11 unpriv read err", last_err, 1);
        chk("R11 unpriv read data", last_rd, 0);
        wr_reg(8'h0, 32'h3);
        rd_reg(8'h0); chk("R11 flag survives unpriv read", last_rd, 32'h0001_0003);

        // R12 source change while armed reloads
        wr_reg(8'h0, 32'h0);
        wr_reg(8'h4, 10);
        wr_reg(8'h0, 32'h7);
        idle(5);
        wr_reg(8'h0, 32'h3);
        wr_reg(8'h0, 32'h7);
        t0 = cyc; base = irq_cnt;
        wait_irq(base + 1);
        chk("R12 reload on source change", irq_stamp[base] - t0, 11);

        // R12 reference strobe edges
        wr_reg(8'h0, 32'h0);
        wr_reg(8'h4, 3);
        wr_reg(8'h0, 32'h3);
        base = irq_cnt;
        for (int p = 0; p < 8; p++) pulse_ref(3, 3);
        idle(6);
        chk("R12 eight edges two wraps", irq_cnt - base, 2);

        wr_reg(8'h0, 32'h0);
        wr_reg(8'h4, 1);
        wr_reg(8'h0, 32'h3);
        base = irq_cnt;
        pulse_ref(20, 5);
        chk("R12 held strobe counts once", irq_cnt - base, 0);
        pulse_ref(3, 6);
        chk("R12 second edge wraps", irq_cnt - base, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule